// File: doc/BRIEF.md
# Two-Wire Control and Status Slave Port

This block is the serial control front end of an audio decoder device. It watches the clock and data lines of a two-wire (I2C) bus from the system clock domain and recognises the bus start and stop conditions. It answers only to one fixed 7-bit device address. A write transfer after that address loads a single 8-bit control byte into an internal register. The decoder core reads that register.

A read transfer returns one status byte. The byte carries two detector flags from the decoder core: a stereo-present flag and a secondary-audio-present flag. The data line is never driven high. The block only asserts an enable that pulls the line low, for acknowledge bits and for zero bits of read data.

Both bus lines pass through a two-stage synchronizer before any edge detection. The system clock must therefore run at least several times faster than the bus clock.

Top module: `i2c_status_port`

## Requirements
- R1: While reset is asserted and after it is released, `ctrl_q` is 0x00 and `sda_pull` is 0 (line released).
- R2: The first byte after a start condition (SDA falling while SCL is high) is sampled MSB first on SCL rising edges. Its upper 7 bits are the address and bit 0 is the direction, with 0 meaning write and 1 meaning read. When the address equals 7'b1000000, the port pulls SDA low during the whole high phase of the 9th SCL clock.
- R3: In a write transfer, the next 8 bits are taken MSB first, and `ctrl_q` takes the full byte once the 8th bit is sampled. The port then pulls SDA low during the 9th clock.
- R4: A stop condition (SDA rising while SCL is high) that arrives before the 8th bit of the control byte leaves `ctrl_q` unchanged.
- R5: After an address that does not match, the port gives no acknowledge and keeps SDA released. It ignores further bytes, and `ctrl_q` stays unchanged, until the next start condition.
- R6: In a read transfer, the status byte is sent MSB first. Bit 7 is the stereo flag (1 = stereo), bit 6 is the secondary-audio flag (1 = present), and bits 5..0 are 0. A 1 bit is sent by leaving SDA released, and a 0 bit by pulling it low.
- R7: The status byte is captured from the detector inputs when the address acknowledge clock of a read ends. Later changes of those inputs do not alter the bytes of that transfer.
- R8: After each read byte, the port releases SDA for the 9th clock and samples the master's bit. A 0 (ACK) makes the port send the same captured byte again. A 1 (NACK) makes it stop driving until the next start condition.
- R9: A start condition at any point, including in the middle of a byte, restarts address reception.
- R10: `sda_pull` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain enable) |
| stereo_det | input | 1 | Stereo-present flag from the decoder core |
| sap_det | input | 1 | Secondary-audio-present flag from the decoder core |
| ctrl_q | output | 8 | Control register contents |

## Verification
Two functions can compete with the last data bit of a write: the commit of the control byte, and the discarding of the byte by a stop or a restart. The bench ends one write with a stop after five bits. It cuts another short with a restart after three address bits and then finishes a complete write. Each case is judged by reading `ctrl_q` against the last fully received byte. The status capture also competes with changes on the detector inputs. The bench toggles the flags right after the address acknowledge and expects every repeated byte to carry the values present at capture.

// File: rtl/i2c_sp_pkg.sv
// Package: shared state type for the two-wire status port.
// Assumes: one engine instance uses this encoding; no other block decodes it.
package i2c_sp_pkg;

    typedef enum logic [3:0] {
        S_IDLE,     // bus free, waiting for start
        S_ADDR,     // receiving address byte
        S_AACK_W,   // address matched, waiting for SCL low to pull
        S_AACK,     // pulling ACK for address
        S_WDATA,    // receiving control byte
        S_WACK_W,   // byte done, waiting for SCL low to pull
        S_WACK,     // pulling ACK for control byte
        S_RDATA,    // sending status bits
        S_RACK,     // released, waiting for master ACK/NACK
        S_RREP,     // master acked, reload on next SCL low
        S_IGNORE    // silent until next start
    } sp_state_t;

endpackage

// File: rtl/i2c_sp_sync.sv
// Module: multi-stage synchronizer for asynchronous bus lines.
// Assumes: inputs are level signals that idle high; STAGES >= 2.
module i2c_sp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift each line through its own flop chain, idle value high.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d[i]};
        end

        assign q[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/i2c_sp_cond.sv
// Module: bus event detector working on synchronized SCL and SDA.
// Assumes: inputs are already synchronous to clk; both lines idle high.
// Gives one-cycle pulses for SCL edges and for start and stop conditions.
module i2c_sp_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_p;
    logic sda_p;

    // Hold the previous samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Decode edges; SDA moves while SCL stays high mark start/stop.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/i2c_status_port.sv
// Module: two-wire slave with one write-only control byte and one read-only
// status byte.
// Assumes: clk is several times faster than SCL; SDA is wired open-drain
// outside, so sda_pull = 1 means the line is pulled low. No clock stretching.
module i2c_status_port #(
    parameter int         DW       = 8,
    parameter logic [6:0] SLV_ADDR = 7'b1000000,
    parameter int         SYNC_STG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_pull,
    input  logic          stereo_det,
    input  logic          sap_det,
    output logic [DW-1:0] ctrl_q
);
    import i2c_sp_pkg::*;

    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    logic          scl_s, sda_s;
    logic          scl_rise, scl_fall, start_det, stop_det;
    sp_state_t     st;
    logic [CW-1:0] cnt;
    logic [DW-2:0] sh;
    logic [DW-2:0] rsh;
    logic [DW-1:0] stat_q;
    logic          rw;
    logic [DW-1:0] rx_byte;
    logic [DW-1:0] stat_now;
    logic          last;

    i2c_sp_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     ({scl_s, sda_s})
    );

    i2c_sp_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // Assemble the received byte and the live status byte.
    always_comb begin
        rx_byte  = {sh, sda_s};
        stat_now = {stereo_det, sap_det, {(DW-2){1'b0}}};
        last     = (cnt == LAST_BIT);
    end

    // Transfer engine: bit counting, acknowledge, control commit, status send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            cnt      <= '0;
            sh       <= '0;
            rsh      <= '0;
            stat_q   <= '0;
            rw       <= 1'b0;
            sda_pull <= 1'b0;
            ctrl_q   <= '0;
        end else if (start_det) begin
            st       <= S_ADDR;
            cnt      <= '0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            st       <= S_IDLE;
            cnt      <= '0;
            sda_pull <= 1'b0;
        end else begin
            case (st)
                S_ADDR: if (scl_rise) begin
                    sh <= rx_byte[DW-2:0];
                    if (last) begin
                        cnt <= '0;
                        rw  <= rx_byte[0];
                        st  <= (rx_byte[DW-1 -: 7] == SLV_ADDR) ? S_AACK_W : S_IGNORE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_AACK_W: if (scl_fall) begin
                    sda_pull <= 1'b1;
                    st       <= S_AACK;
                end
                S_AACK: if (scl_fall) begin
                    cnt <= '0;
                    if (rw) begin
                        stat_q   <= stat_now;
                        rsh      <= stat_now[DW-2:0];
                        sda_pull <= ~stat_now[DW-1];
                        st       <= S_RDATA;
                    end else begin
                        sda_pull <= 1'b0;
                        st       <= S_WDATA;
                    end
                end
                S_WDATA: if (scl_rise) begin
                    sh <= rx_byte[DW-2:0];
                    if (last) begin
                        cnt    <= '0;
                        ctrl_q <= rx_byte;
                        st     <= S_WACK_W;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_WACK_W: if (scl_fall) begin
                    sda_pull <= 1'b1;
                    st       <= S_WACK;
                end
                S_WACK: if (scl_fall) begin
                    sda_pull <= 1'b0;
                    st       <= S_IGNORE;
                end
                S_RDATA: if (scl_fall) begin
                    if (last) begin
                        cnt      <= '0;
                        sda_pull <= 1'b0;
                        st       <= S_RACK;
                    end else begin
                        cnt      <= cnt + 1'b1;
                        sda_pull <= ~rsh[DW-2];
                        rsh      <= {rsh[DW-3:0], 1'b0};
                    end
                end
                S_RACK: if (scl_rise) begin
                    st <= sda_s ? S_IGNORE : S_RREP;
                end
                S_RREP: if (scl_fall) begin
                    rsh      <= stat_q[DW-2:0];
                    sda_pull <= ~stat_q[DW-1];
                    st       <= S_RDATA;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2c_sp_chk.sv
// Module: property checker for the status port, bound into the top module.
// Assumes: it sees the synchronized SCL and the engine state by name.
module i2c_sp_chk #(
    parameter int DW = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  scl_rise,
    input logic                  sda_pull,
    input logic [DW-1:0]         ctrl_q,
    input logic [DW-1:0]         stat_q,
    input i2c_sp_pkg::sp_state_t st
);
    import i2c_sp_pkg::*;

    // R1: reset forces register and line to their idle values.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0 && !sda_pull));

    // R4: the control register moves only right after an SCL rising edge.
    p_commit_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(scl_rise));

    // R5: in the idle and silent states the line stays released.
    p_quiet_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IGNORE || st == S_IDLE) |-> !sda_pull);

    // R7: the captured status stays fixed while bits are being sent.
    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RDATA && $past(st) == S_RDATA) |-> $stable(stat_q));

    // R10: the pull enable never moves while SCL stays high.
    p_pull_low_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull));

endmodule

bind i2c_status_port i2c_sp_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .scl_rise (scl_rise),
    .sda_pull (sda_pull),
    .ctrl_q   (ctrl_q),
    .stat_q   (stat_q),
    .st       (st)
);

// File: tb/i2c_status_port_tb.sv
// Bench: bus master tasks push expected values into a scoreboard queue;
// the monitor task pops and compares each observed value.
module i2c_status_port_tb;

    localparam int Q = 10;              // clk cycles per quarter SCL period
    localparam logic [7:0] WR = 8'h80;  // address 1000000, write
    localparam logic [7:0] RD = 8'h81;  // address 1000000, read

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       stereo_det = 1'b0;
    logic       sap_det = 1'b0;
    logic       sda_pull;
    logic [7:0] ctrl_q;
    logic       sda_bus;

    typedef struct {
        string      req;
        logic [7:0] val;
    } exp_t;

    exp_t sb_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    assign sda_bus = m_sda & ~sda_pull;

    always #10 clk = ~clk;

    i2c_status_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_pull   (sda_pull),
        .stereo_det (stereo_det),
        .sap_det    (sap_det),
        .ctrl_q     (ctrl_q)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_val(input string req, input logic [7:0] v);
        exp_t e;
        e.req = req;
        e.val = v;
        sb_q.push_back(e);
    endtask

    // Monitor: pop the oldest expectation and compare with the observation.
    task automatic observe(input logic [7:0] act);
        exp_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if (act !== e.val) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", e.req, act, e.val);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    wq(Q);
        m_scl = 1'b1; wq(2 * Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        b = sda_bus;  wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    // Send a byte; return 1 when the slave acknowledged.
    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) get_bit(b[i]);
        put_bit(nack);
    endtask

    initial begin
        logic       ack;
        logic [7:0] rb;

        wq(5);
        expect_val("R1 ctrl at reset", 8'h00);
        observe(ctrl_q);
        expect_val("R1 pull at reset", 8'h00);
        observe({7'd0, sda_pull});
        rst_n = 1'b1;
        wq(5);
        expect_val("R1 ctrl after reset", 8'h00);
        observe(ctrl_q);

        // R2, R3: full write of 0xA5.
        bus_start();
        send_byte(WR, ack);
        expect_val("R2 address ack", 8'h01); observe({7'd0, ack});
        send_byte(8'hA5, ack);
        expect_val("R3 data ack", 8'h01); observe({7'd0, ack});
        bus_stop();
        expect_val("R3 ctrl after write", 8'hA5); observe(ctrl_q);

        // R3 again, then R4: stop after five bits keeps 0x3C.
        bus_start();
        send_byte(WR, ack);
        send_byte(8'h3C, ack);
        bus_stop();
        expect_val("R3 ctrl second write", 8'h3C); observe(ctrl_q);
        bus_start();
        send_byte(WR, ack);
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        bus_stop();
        expect_val("R4 ctrl after partial byte", 8'h3C); observe(ctrl_q);

        // R5: foreign address is not acknowledged and its data ignored.
        bus_start();
        send_byte(8'h82, ack);
        expect_val("R5 no ack on wrong address", 8'h00); observe({7'd0, ack});
        send_byte(8'h00, ack);
        expect_val("R5 no ack on ignored data", 8'h00); observe({7'd0, ack});
        bus_stop();
        expect_val("R5 ctrl unchanged", 8'h3C); observe(ctrl_q);

        // R6, R7, R8: read with stereo only, flags change after capture.
        stereo_det = 1'b1; sap_det = 1'b0;
        bus_start();
        send_byte(RD, ack);
        expect_val("R2 read address ack", 8'h01); observe({7'd0, ack});
        stereo_det = 1'b0; sap_det = 1'b1;
        recv_byte(1'b0, rb);
        expect_val("R6 status stereo only", 8'h80); observe(rb);
        recv_byte(1'b1, rb);
        expect_val("R7 R8 repeated byte keeps capture", 8'h80); observe(rb);
        recv_byte(1'b1, rb);
        expect_val("R8 released after NACK", 8'hFF); observe(rb);
        bus_stop();

        // R6: both flags set, then neither.
        stereo_det = 1'b1; sap_det = 1'b1;
        bus_start();
        send_byte(RD, ack);
        recv_byte(1'b1, rb);
        bus_stop();
        expect_val("R6 status both flags", 8'hC0); observe(rb);
        stereo_det = 1'b0; sap_det = 1'b0;
        bus_start();
        send_byte(RD, ack);
        recv_byte(1'b1, rb);
        bus_stop();
        expect_val("R6 status no flags", 8'h00); observe(rb);

        // R9: restart in the middle of the address byte.
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send_byte(WR, ack);
        expect_val("R9 ack after restart", 8'h01); observe({7'd0, ack});
        send_byte(8'h11, ack);
        bus_stop();
        expect_val("R9 ctrl after restart", 8'h11); observe(ctrl_q);

        // R9: restart from the silent state after a foreign address.
        bus_start();
        send_byte(8'h10, ack);
        bus_start();
        send_byte(WR, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        expect_val("R9 restart from ignore", 8'h5A); observe(ctrl_q);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule